// File: doc/BRIEF.md
# Two-Step Integrator Code Reconstruction

This block forms one extended-range signed energy code for a single channel of a charge-integrating front end. The analog integrator is held in range by charge injections. A removal request fires when the integrator crosses its upper threshold, and an addition request fires when it crosses its lower threshold. Both requests arrive asynchronously. The block counts them during an integration window and keeps the net count. That net count, scaled by a calibrated pulse height, gives the coarse part of the result. The fine part is the converter sample taken at window end minus the sample taken at window start. That difference also removes baseline offset and slow drift.

A window opens on `win_start`, which clears the counts. It closes on `win_end`, which freezes the net count together with the start sample and the pulse height used for that window. The frozen result waits for the end sample on `b_valid`, and the code is issued one cycle after that sample arrives. While the result waits, a new window may already open and count. The pulse height is written through `cal_we` and is adopted only when the next window opens.

Top module: `twostep_code_rebuild`

## Requirements
- R1: After reset, `code_valid` and `code_sat` are 0 and `code_out` is 0.
- R2: Each removal request (rising edge on `dn_req`) inside an open window adds one to the down count. A request line held high for several cycles counts once.
- R3: Each addition request (rising edge on `up_req`) inside an open window adds one to the up count. The net count is down minus up, so more addition pulses give a negative code.
- R4: The fine part is `b_sample - a_sample`, with both samples taken as unsigned 8-bit codes. A sample pair with B below A gives a negative contribution.
- R5: One cycle after `b_valid` is high while a frozen result is pending, `code_valid` is high for exactly one cycle and `code_out` = net × height + (B − A) as a signed two's-complement value.
- R6: `win_start` clears both counts, so requests that arrive before a window opens have no effect on its code.
- R7: Requests that arrive after `win_end` do not change the frozen result.
- R8: Each direction's count saturates at 2^CNT_W − 1, which is 127 by default. `code_sat` is 1 with the code when a request arrived while its count was already at that limit, and is 0 otherwise.
- R9: A height written with `cal_we` while a window is open does not change that window's code. It applies from the next `win_start` onward.
- R10: A new window may open and capture its own A sample while an earlier result still waits for B. The earlier code is still computed from its own count, height and A sample.
- R11: `b_valid` with no pending result produces no `code_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dn_req | input | 1 | Asynchronous charge-removal pulse request |
| up_req | input | 1 | Asynchronous charge-addition pulse request |
| win_start | input | 1 | Opens a window; clears counts and adopts the height |
| win_end | input | 1 | Closes the open window and freezes its result |
| a_valid | input | 1 | Captures the start sample |
| a_sample | input | SAMPLE_W | Start-of-window converter code |
| b_valid | input | 1 | Delivers the end sample of the pending result |
| b_sample | input | SAMPLE_W | End-of-window converter code |
| cal_we | input | 1 | Writes the pulse height register |
| cal_height | input | HEIGHT_W | Measured height of one charge pulse, in LSBs |
| code_out | output | OUT_W | Signed reconstructed code |
| code_valid | output | 1 | One-cycle strobe for `code_out` |
| code_sat | output | 1 | A count saturated in the window of this code |

## Verification
The assertions rely on the window controls arriving in order: `win_end` only while a window is open, and at most one `b_valid` for each closed window. They also rely on the request lines staying low long enough between pulses for each rising edge to pass through the synchronisers. The stimulus opens and closes each window with single-cycle strobes. It spaces pulses three cycles high and three cycles low, and leaves a few cycles of drain before closing a window. Random windows draw the pulse counts, samples and height from a seeded generator. Directed cases then cover saturation, late heights, early and late requests, and overlapping windows.

// File: rtl/twostep_code_rebuild.sv
module twostep_code_rebuild #(
  parameter int SAMPLE_W = 8,
  parameter int CNT_W    = 7,
  parameter int HEIGHT_W = 8,
  localparam int OUT_W   = CNT_W + HEIGHT_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dn_req,
  input  logic                    up_req,
  input  logic                    win_start,
  input  logic                    win_end,
  input  logic                    a_valid,
  input  logic [SAMPLE_W-1:0]     a_sample,
  input  logic                    b_valid,
  input  logic [SAMPLE_W-1:0]     b_sample,
  input  logic                    cal_we,
  input  logic [HEIGHT_W-1:0]     cal_height,
  output logic signed [OUT_W-1:0] code_out,
  output logic                    code_valid,
  output logic                    code_sat
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [2:0] dn_sy, up_sy;
  logic dn_hit, up_hit;
  logic active, sat_run, sat_held, pending;
  logic [CNT_W-1:0] cnt_dn, cnt_up;
  logic [HEIGHT_W-1:0] h_reg, h_act, h_held;
  logic [SAMPLE_W-1:0] a_cur, a_held;
  logic signed [CNT_W:0] net_held;
  logic signed [OUT_W-1:0] coarse, fine;
  logic close_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_sy <= '0;
      up_sy <= '0;
    end else begin
      dn_sy <= {dn_sy[1:0], dn_req};
      up_sy <= {up_sy[1:0], up_req};
    end
  end

  assign dn_hit    = dn_sy[1] & ~dn_sy[2];
  assign up_hit    = up_sy[1] & ~up_sy[2];
  assign close_win = win_end & active & ~win_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt_dn  <= '0;
      cnt_up  <= '0;
      sat_run <= 1'b0;
      h_act   <= '0;
    end else if (win_start) begin
      active  <= 1'b1;
      cnt_dn  <= '0;
      cnt_up  <= '0;
      sat_run <= 1'b0;
      h_act   <= h_reg;
    end else if (close_win) begin
      active <= 1'b0;
    end else if (active) begin
      if (dn_hit) begin
        if (cnt_dn == CNT_MAX) sat_run <= 1'b1;
        else cnt_dn <= cnt_dn + 1'b1;
      end
      if (up_hit) begin
        if (cnt_up == CNT_MAX) sat_run <= 1'b1;
        else cnt_up <= cnt_up + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_reg    <= '0;
      a_cur    <= '0;
      a_held   <= '0;
      h_held   <= '0;
      net_held <= '0;
      sat_held <= 1'b0;
      pending  <= 1'b0;
    end else begin
      if (cal_we) h_reg <= cal_height;
      if (a_valid) a_cur <= a_sample;
      if (close_win) begin
        net_held <= $signed({1'b0, cnt_dn}) - $signed({1'b0, cnt_up});
        h_held   <= h_act;
        a_held   <= a_cur;
        sat_held <= sat_run;
        pending  <= 1'b1;
      end else if (b_valid) begin
        pending <= 1'b0;
      end
    end
  end

  assign coarse = OUT_W'(net_held) * OUT_W'($signed({1'b0, h_held}));
  assign fine   = OUT_W'($signed({1'b0, b_sample})) - OUT_W'($signed({1'b0, a_held}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_out   <= '0;
      code_valid <= 1'b0;
      code_sat   <= 1'b0;
    end else begin
      code_valid <= b_valid & pending;
      if (b_valid && pending) begin
        code_out <= coarse + fine;
        code_sat <= sat_held;
      end
    end
  end

  AST_VALID_AFTER_B: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> $past(b_valid)); // R5
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |=> !code_valid || $past(b_valid)); // R5
  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |=> cnt_dn == '0 && cnt_up == '0); // R6
  AST_FROZEN_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !win_start) |=> $stable(cnt_dn) && $stable(cnt_up)); // R7
  AST_HEIGHT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !win_start) |=> $stable(h_act)); // R9
  AST_NO_STRAY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && !pending) |=> !code_valid); // R11
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt_dn == CNT_MAX) |=> cnt_dn == CNT_MAX || $past(win_start)); // R8
endmodule

// File: tb/twostep_code_rebuild_tb.sv
module twostep_code_rebuild_tb;
  localparam int OUT_W = 17;
  logic clk = 0, rst_n = 0;
  logic dn_req = 0, up_req = 0, win_start = 0, win_end = 0;
  logic a_valid = 0, b_valid = 0, cal_we = 0;
  logic [7:0] a_sample = 0, b_sample = 0, cal_height = 0;
  logic signed [OUT_W-1:0] code_out;
  logic code_valid, code_sat;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  twostep_code_rebuild u_dut (
    .clk(clk), .rst_n(rst_n), .dn_req(dn_req), .up_req(up_req),
    .win_start(win_start), .win_end(win_end), .a_valid(a_valid),
    .a_sample(a_sample), .b_valid(b_valid), .b_sample(b_sample),
    .cal_we(cal_we), .cal_height(cal_height), .code_out(code_out),
    .code_valid(code_valid), .code_sat(code_sat));

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint exp_code(int nd, int nu, int h, int a, int b);
    int cd = nd > 127 ? 127 : nd;
    int cu = nu > 127 ? 127 : nu;
    return longint'((cd - cu) * h + b - a);
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(int nd, int nu);
    for (int i = 0; i < nd; i++) begin dn_req = 1; tick(3); dn_req = 0; tick(3); end
    for (int i = 0; i < nu; i++) begin up_req = 1; tick(3); up_req = 0; tick(3); end
  endtask

  task automatic set_h(int h);
    cal_we = 1; cal_height = 8'(h); tick(1); cal_we = 0;
  endtask

  task automatic open_win(int a);
    win_start = 1; a_valid = 1; a_sample = 8'(a); tick(1);
    win_start = 0; a_valid = 0;
  endtask

  task automatic close_win();
    tick(4); win_end = 1; tick(1); win_end = 0;
  endtask

  task automatic give_b(string tag, int b, longint exp, int exp_sat);
    b_sample = 8'(b); b_valid = 1; tick(1); b_valid = 0;
    chk({tag, " valid"}, code_valid, 1);
    chk({tag, " code"}, longint'(code_out), exp);
    chk({tag, " sat"}, code_sat, exp_sat);
    tick(1);
    chk({tag, " valid drop"}, code_valid, 0);
  endtask

  initial begin
    #(5 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(1234);
    tick(3);
    chk("R1 reset valid", code_valid, 0);
    chk("R1 reset code", longint'(code_out), 0);
    chk("R1 reset sat", code_sat, 0);
    rst_n = 1; tick(2);

    // R11: stray B
    b_valid = 1; b_sample = 8'd9; tick(1); b_valid = 0;
    chk("R11 stray b", code_valid, 0);

    // R2 with held-high request counted once
    set_h(20);
    open_win(10);
    dn_req = 1; tick(12); dn_req = 0; tick(3);
    pulses(2, 0);
    close_win();
    give_b("R2", 15, exp_code(3, 0, 20, 10, 15), 0);

    // R3 and R4: negative net, B below A
    open_win(200);
    pulses(1, 4);
    close_win();
    give_b("R3 R4", 50, exp_code(1, 4, 20, 200, 50), 0);

    // R6: requests before window; R7: requests after end
    pulses(3, 2);
    tick(4);
    open_win(0);
    pulses(2, 0);
    close_win();
    pulses(5, 1);
    tick(4);
    give_b("R6 R7", 255, exp_code(2, 0, 20, 0, 255), 0);

    // R9: height written mid-window
    open_win(30);
    pulses(2, 0);
    set_h(100);
    close_win();
    give_b("R9 old", 40, exp_code(2, 0, 20, 30, 40), 0);
    open_win(30);
    pulses(2, 0);
    close_win();
    give_b("R9 new", 40, exp_code(2, 0, 100, 30, 40), 0);

    // R10: overlapping windows
    set_h(7);
    open_win(11);
    pulses(3, 0);
    close_win();
    open_win(99);
    pulses(0, 2);
    give_b("R10 first", 20, exp_code(3, 0, 7, 11, 20), 0);
    close_win();
    give_b("R10 second", 60, exp_code(0, 2, 7, 99, 60), 0);

    // R8: exactly at limit, then beyond
    set_h(255);
    open_win(0);
    pulses(127, 0);
    close_win();
    give_b("R8 at limit", 255, exp_code(127, 0, 255, 0, 255), 0);
    open_win(255);
    pulses(130, 1);
    close_win();
    give_b("R8 saturate", 0, exp_code(130, 1, 255, 255, 0), 1);
    open_win(5);
    pulses(0, 129);
    close_win();
    give_b("R8 up sat", 5, exp_code(0, 129, 255, 5, 5), 1);

    // R5 random windows
    for (int k = 0; k < 40; k++) begin
      int nd = int'($urandom_range(0, 20));
      int nu = int'($urandom_range(0, 20));
      int h  = int'($urandom_range(0, 255));
      int a  = int'($urandom_range(0, 255));
      int b  = int'($urandom_range(0, 255));
      set_h(h);
      open_win(a);
      pulses(nd, nu);
      close_win();
      tick(int'($urandom_range(0, 3)));
      give_b("R5 random", b, exp_code(nd, nu, h, a, b), 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule